// File: doc/BRIEF.md
# Double-Buffered UART Transmitter with Clear-to-Send Gating

This block is the transmit half of an asynchronous serial port. The host places a character in a holding register with a one-cycle write strobe. The block then moves it into a shift stage and sends it as a frame on a line that idles high. Time inside the block is counted in baud ticks. A baud tick is a one-cycle enable that arrives at sixteen times the bit rate. Each serial bit lasts sixteen ticks.

The hand-off from holding register to shifter happens at fixed tick counts, not on bit edges. If the shifter is idle, the hand-off comes a few ticks after the write. If a frame is in flight, the hand-off comes just before that frame's last stop bit ends, so the next start bit follows with no idle gap. An active-low clear-to-send input holds back a waiting character. A one-cycle completion pulse marks a frame that ends with nothing queued behind it.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `tc_pulse` is 0.
- R2: A frame is one low start bit, then N data bits LSB first, then an optional parity bit, then 1 or 2 high stop bits. Each bit lasts 16 ticks.
  - N is 5, 6, 7 or 8 for `fmt_wlen` codes 0, 1, 2 and 3.
  - Even parity (`par_odd`=0) is the XOR of the N data bits. Odd parity is its inverse.
  - `two_stop`=1 selects two stop bits.
  - Data bits above N are ignored.
- R3: A write while the shifter is idle and `cts_n` is low does the following:
  - `buf_empty` goes low on the next clock.
  - `buf_empty` rises on the 4th tick after the strobe.
  - `txd` drops for the start bit on the 5th tick after the strobe.
- R4: If a character is waiting by tick 12 of a frame's last stop bit and `cts_n` is low, then:
  - `buf_empty` rises on tick 15 of that stop bit.
  - The next start bit begins on tick 16, with no idle tick between frames.
- R5: A character written after tick 12 of the last stop bit is not chained. The frame ends with `txd` high. The hand-off occurs on the 4th tick after the frame end and the start bit on the 5th.
- R6: While `cts_n` is high and the shifter is idle, a waiting character stays in the holding register and `txd` stays high. After `cts_n` falls, `buf_empty` rises on the 4th tick and the start bit begins on the 5th.
- R7: Chaining depends on when `cts_n` goes high relative to tick 12 of the last stop bit:
  - High at or before tick 12: the waiting character is not chained, and the line goes idle.
  - High only after tick 12: the chained start bit is not blocked.
- R8: `tc_pulse` is high for one clock on tick 11 of a frame's last stop bit, but only if the holding register is empty at that moment. It is never high otherwise.
- R9: A write while the holding register is full replaces its content without error. The frame sent carries the latest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character to transmit |
| fmt_wlen | input | 2 | Data length code: 0..3 selects 5..8 bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial data line, idle high |
| buf_empty | output | 1 | Holding register is free for a new character |
| tc_pulse | output | 1 | One-cycle pulse when a frame ends with nothing queued |

## Verification
Frame layout is checked with a table of characters that covers every length code, each parity sense, and both stop counts. Some characters carry set bits above the selected length, which separates correct masking from a fixed eight-bit shift. Four directed scenarios then exercise hand-off timing:
- a write during a frame, which must chain back-to-back;
- a write after tick 12 of the last stop bit, which must fall back to the idle delay;
- a held clear-to-send with an overwrite, which separates gating from loss of the newest character;
- clear-to-send raised on either side of tick 12, which separates blocking from a too-late request.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

    localparam int OVS             = 16;
    localparam int PH_W            = $clog2(OVS);
    localparam int DMAX            = 8;
    localparam int FRAME_MAX       = 1 + DMAX + 1 + 2;
    localparam int NB_W            = $clog2(FRAME_MAX + 1);
    localparam int IDLE_XFER_TICK  = 4;
    localparam int TC_TICK         = OVS - 5;
    localparam int GATE_TICK       = OVS - 4;
    localparam int CHAIN_XFER_TICK = OVS - 1;

    typedef enum logic [1:0] {
        WLEN5 = 2'd0,
        WLEN6 = 2'd1,
        WLEN7 = 2'd2,
        WLEN8 = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wlen;
        logic  par_en;
        logic  par_odd;
        logic  two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [NB_W-1:0]      nbits;
    } frame_t;

    function automatic int data_len(wlen_e w);
        return 5 + int'(w);
    endfunction

    // Bit 0 goes out first; unused upper positions stay high (stop level).
    function automatic frame_t build_frame(logic [DMAX-1:0] d, fmt_t f);
        frame_t fr;
        int     pos;
        int     nd;
        logic   par;
        fr.bits = '1;
        fr.bits[0] = 1'b0;
        pos = 1;
        nd  = data_len(f.wlen);
        par = f.par_odd;
        for (int i = 0; i < DMAX; i++) begin
            if (i < nd) begin
                fr.bits[pos] = d[i];
                par = par ^ d[i];
                pos = pos + 1;
            end
        end
        if (f.par_en) begin
            fr.bits[pos] = par;
            pos = pos + 1;
        end
        pos = pos + (f.two_stop ? 2 : 1);
        fr.nbits = NB_W'(pos);
        return fr;
    endfunction

endpackage

// File: rtl/uart_tx_holdbuf.sv
`timescale 1ns/1ps
module uart_tx_holdbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] data_q,
    output logic          full_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr_en) begin
                data_q <= wr_data;
                full_q <= 1'b1;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> full_q);

    a_r9_write_wins_take: assert property (@(posedge clk) disable iff (rst)
        (wr_en && take) |=> (full_q && data_q == $past(wr_data)));

endmodule

// File: rtl/uart_tx_launch.sv
`timescale 1ns/1ps
module uart_tx_launch
    import uart_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wr_en,
    input  logic cts_n,
    input  logic buf_full,
    input  logic busy,
    output logic fire
);

    localparam int CW = $clog2(IDLE_XFER_TICK);

    logic [CW-1:0] cnt_q;
    logic          hold;

    assign hold = wr_en || cts_n || busy || !buf_full;
    assign fire = tick && !hold && (cnt_q == CW'(IDLE_XFER_TICK - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == CW'(IDLE_XFER_TICK - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    a_r6_no_fire_without_cts: assert property (@(posedge clk) disable iff (rst)
        $past(cts_n) |-> !fire || (cnt_q == '0 && IDLE_XFER_TICK == 1));

endmodule

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t load_frame,
    output logic   txd,
    output logic   busy,
    output logic   mark_tc,
    output logic   mark_gate,
    output logic   mark_xfer
);

    logic                 active_q;
    logic                 pend_q;
    frame_t               pend_f;
    logic [FRAME_MAX-1:0] sh_q;
    logic [NB_W-1:0]      left_q;
    logic [PH_W-1:0]      ph_q;

    logic bit_end, last_bit, frame_end, launch, last_tick;

    assign last_bit  = (left_q == '0);
    assign bit_end   = active_q && tick && (ph_q == PH_W'(OVS - 1));
    assign frame_end = bit_end && last_bit;
    assign launch    = pend_q && tick && (!active_q || frame_end);
    assign last_tick = active_q && last_bit && tick;

    assign mark_tc   = last_tick && (ph_q == PH_W'(TC_TICK - 1));
    assign mark_gate = last_tick && (ph_q == PH_W'(GATE_TICK - 1));
    assign mark_xfer = last_tick && (ph_q == PH_W'(CHAIN_XFER_TICK - 1));

    assign txd  = active_q ? sh_q[0] : 1'b1;
    assign busy = active_q || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            pend_f <= '0;
        end else if (load) begin
            pend_q <= 1'b1;
            pend_f <= load_frame;
        end else if (launch) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sh_q     <= '1;
            left_q   <= '0;
            ph_q     <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            sh_q     <= pend_f.bits;
            left_q   <= pend_f.nbits - 1'b1;
            ph_q     <= '0;
        end else if (frame_end) begin
            active_q <= 1'b0;
            ph_q     <= '0;
        end else if (active_q && tick) begin
            ph_q <= (ph_q == PH_W'(OVS - 1)) ? '0 : ph_q + 1'b1;
            if (bit_end) begin
                sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        launch |=> (txd == 1'b0));

    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(tick));

    a_r4_no_load_while_pending: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !load);

endmodule

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf
    import uart_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            baud_tick,
    input  logic            wr_en,
    input  logic [DMAX-1:0] wr_data,
    input  logic [1:0]      fmt_wlen,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            two_stop,
    input  logic            cts_n,
    output logic            txd,
    output logic            buf_empty,
    output logic            tc_pulse
);

    logic [DMAX-1:0] buf_data;
    logic            buf_full;
    logic            take;
    logic            idle_fire;
    logic            sh_busy;
    logic            mark_tc, mark_gate, mark_xfer;
    logic            chain_q;
    logic            tc_q;
    fmt_t            fmt;
    frame_t          next_frame;

    assign fmt.wlen     = wlen_e'(fmt_wlen);
    assign fmt.par_en   = par_en;
    assign fmt.par_odd  = par_odd;
    assign fmt.two_stop = two_stop;
    assign next_frame   = build_frame(buf_data, fmt);

    assign take = idle_fire || (mark_xfer && chain_q);

    uart_tx_holdbuf #(.DW(DMAX)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .data_q  (buf_data),
        .full_q  (buf_full)
    );

    uart_tx_launch launch_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .wr_en    (wr_en),
        .cts_n    (cts_n),
        .buf_full (buf_full),
        .busy     (sh_busy),
        .fire     (idle_fire)
    );

    uart_tx_shifter shift_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .load       (take),
        .load_frame (next_frame),
        .txd        (txd),
        .busy       (sh_busy),
        .mark_tc    (mark_tc),
        .mark_gate  (mark_gate),
        .mark_xfer  (mark_xfer)
    );

    // Chaining decision is frozen at the gate tick of the last stop bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= 1'b0;
        end else if (mark_xfer) begin
            chain_q <= 1'b0;
        end else if (mark_gate) begin
            chain_q <= buf_full && !cts_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tc_q <= 1'b0;
        else     tc_q <= mark_tc && !buf_full;
    end

    assign buf_empty = !buf_full;
    assign tc_pulse  = tc_q;

    a_r4_empty_rises_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> $past(baud_tick));

    a_r6_cts_holds_buffer: assert property (@(posedge clk) disable iff (rst)
        (cts_n && !buf_empty && !sh_busy) |=> !buf_empty);

    a_r8_tc_single_cycle: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

    a_r8_tc_on_tick: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> $past(baud_tick));

endmodule

// File: tb/uart_tx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic [1:0] tdiv;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [1:0] fmt_wlen;
    logic       par_en, par_odd, two_stop;
    logic       cts_n;
    logic       txd, buf_empty, tc_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            tdiv      <= '0;
            baud_tick <= 1'b0;
        end else begin
            tdiv      <= tdiv + 2'd1;
            baud_tick <= (tdiv == 2'd3);
        end
    end

    uart_tx_dbuf dut_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .fmt_wlen  (fmt_wlen),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .cts_n     (cts_n),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tc_pulse  (tc_pulse)
    );

    // {data[7:0], wlen[1:0], par_en, par_odd, two_stop, frame[11:0], nbits[3:0]}
    localparam logic [28:0] VEC [5] = '{
        {8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 12'hEAA, 4'd10},
        {8'h13, 2'd0, 1'b1, 1'b0, 1'b1, 12'hFE6, 4'd9},
        {8'hE6, 2'd1, 1'b1, 1'b1, 1'b0, 12'hF4C, 4'd9},
        {8'h5A, 2'd2, 1'b1, 1'b0, 1'b1, 12'hEB4, 4'd11},
        {8'hFF, 2'd3, 1'b1, 1'b1, 1'b1, 12'hFFE, 4'd12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [11:0] f8n1(input logic [7:0] d);
        return {3'b111, d, 1'b0};
    endfunction

    // Called right after the launch tick; returns at tick 11 of the last stop bit.
    task automatic check_frame(input string req, input logic [11:0] fb, input int n,
                               input logic tc_exp);
        for (int i = 0; i < n; i++) begin
            wait_ticks(8);
            chk(req, txd, fb[i]);
            if (i < n - 1) wait_ticks(8);
            else begin
                wait_ticks(3);
                chk("R8", tc_pulse, tc_exp);
            end
        end
    endtask

    // Idle start: 3rd tick still queued, 4th hand-off, 5th start bit.
    task automatic check_idle_start(input string req);
        wait_ticks(3);
        chk(req, buf_empty, 1'b0);
        chk(req, txd, 1'b1);
        wait_ticks(1);
        chk(req, buf_empty, 1'b1);
        chk(req, txd, 1'b1);
        wait_ticks(1);
        chk(req, txd, 1'b0);
    endtask

    task automatic set_8n1();
        fmt_wlen = 2'd3; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; cts_n = 1'b0;
        set_8n1();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", txd, 1'b1);
        chk("R1", buf_empty, 1'b1);
        chk("R1", tc_pulse, 1'b0);

        // R2 / R3 / R8: formats from the table, each sent from idle
        for (int v = 0; v < 5; v++) begin
            logic [28:0] e;
            e = VEC[v];
            fmt_wlen = e[20:19]; par_en = e[18]; par_odd = e[17]; two_stop = e[16];
            write_char(e[28:21]);
            chk("R3", buf_empty, 1'b0);
            check_idle_start("R3");
            check_frame("R2", e[15:4], int'(e[3:0]), 1'b1);
            wait_ticks(5);
            chk("R2", txd, 1'b1);
        end

        // R4: early write chains back-to-back; R5: late write does not
        set_8n1();
        write_char(8'hA5);
        check_idle_start("R3");
        write_char(8'h3C);
        check_frame("R2", f8n1(8'hA5), 10, 1'b0);
        wait_ticks(3);
        chk("R4", buf_empty, 1'b0);
        wait_ticks(1);
        chk("R4", buf_empty, 1'b1);
        chk("R4", txd, 1'b1);
        wait_ticks(1);
        chk("R4", txd, 1'b0);
        check_frame("R4", f8n1(8'h3C), 10, 1'b1);
        wait_ticks(2);
        write_char(8'hC3);
        wait_ticks(2);
        chk("R5", buf_empty, 1'b0);
        wait_ticks(1);
        chk("R5", txd, 1'b1);
        check_idle_start("R5");
        check_frame("R5", f8n1(8'hC3), 10, 1'b1);
        wait_ticks(5);

        // R6 hold under clear-to-send, R9 overwrite
        cts_n = 1'b1;
        write_char(8'h11);
        wait_ticks(2);
        write_char(8'h96);
        wait_ticks(10);
        chk("R6", buf_empty, 1'b0);
        chk("R6", txd, 1'b1);
        cts_n = 1'b0;
        check_idle_start("R6");
        check_frame("R9", f8n1(8'h96), 10, 1'b1);
        wait_ticks(5);

        // R7: clear-to-send high early in the frame blocks chaining
        write_char(8'h42);
        check_idle_start("R3");
        write_char(8'h7E);
        cts_n = 1'b1;
        check_frame("R7", f8n1(8'h42), 10, 1'b0);
        wait_ticks(4);
        chk("R7", buf_empty, 1'b0);
        wait_ticks(1);
        chk("R7", txd, 1'b1);
        wait_ticks(8);
        chk("R7", txd, 1'b1);
        chk("R7", buf_empty, 1'b0);
        cts_n = 1'b0;
        check_idle_start("R7");
        write_char(8'h81);
        check_frame("R7", f8n1(8'h7E), 10, 1'b0);
        // R7: raised at tick 13, too late to block
        wait_ticks(2);
        cts_n = 1'b1;
        wait_ticks(2);
        chk("R7", buf_empty, 1'b1);
        wait_ticks(1);
        chk("R7", txd, 1'b0);
        check_frame("R7", f8n1(8'h81), 10, 1'b1);
        wait_ticks(5);
        cts_n = 1'b0;
        chk("R8", tc_pulse, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule